// File: doc/BRIEF.md
# Wide Transfer Request Decider

A bus bridge master calls on this block at the start of each transaction it is about to begin. The block decides whether that transaction may use the 64-bit data path. It then drives the active-low wide-request strobe so that the strobe moves on exactly the same clock edges as the frame strobe. The master gives a one-cycle `start` pulse together with a description of the transaction: its command class, its starting DWORD address and length, the cache line size, the direction, and whether it resumes an earlier disconnected write. For a resumed write it also gives how the previous target ended. The block evaluates every rule that forces a narrow transfer, registers the outcome on that edge as `wide_mode`, and holds it until the next `start`.

The wide path is the exception. Any single narrowing condition wins, and 64-bit mode is chosen only when none of them applies. For upstream transactions only, wide operation is also disabled when the upstream side did not assert its own wide-request line while in reset. The block samples that line on every clock edge during reset and keeps the last sample until the next reset.

The near-top rule is defined here as follows: the start DWORD lies in the last quadword of its cache line. A wide burst starting there would immediately cross the line boundary. Because quadword-aligned starts are always even DWORD offsets, this rule is separate from the alignment rule.

Top module: `wide_req_decider`

## Requirements
- R1: `wide_req_n` is 0 exactly in those cycles where `frame_n` is 0 and `wide_mode` is 1. It is 1 at all other times, so it changes only when `frame_n` does while the mode is held.
- R2: Command encodings are 0 prefetchable memory read, 1 non-prefetchable memory read, 2 memory write, 3 I/O, 4 configuration, 5 special cycle, and 6 and 7 unused. Every class other than 0 and 2 gives `wide_mode` 0.
- R3: A start DWORD address with bit 0 set (byte address bit 2, not quadword aligned) gives `wide_mode` 0.
- R4: With `line_dw` a power of two of at least 8 DWORDs, a start whose offset within the line (`start_dwa` modulo `line_dw`) is `line_dw`-2 or `line_dw`-1 gives `wide_mode` 0.
- R5: A prefetchable memory read with `dw_count` of 1 or less gives `wide_mode` 0.
- R6: A memory write with `dw_count` of 2 or less gives `wide_mode` 0.
- R7: `up_wide_rst_n` is sampled on every clock edge with `rst_n` low, and its last sample is held after reset. If that held level is 1 (not asserted), an upstream transaction (`upstream`=1) gives `wide_mode` 0. Downstream transactions are not affected by this rule.
- R8: A memory write with `resume`=1, `prev_ack_wide`=0 and `prev_retry`=0 gives `wide_mode` 0. When `prev_retry`=1, when `resume`=0, or when the command is a read, this rule has no effect.
- R9: When none of the rules R2 to R8 applies, `wide_mode` becomes 1.
- R10: `wide_mode` takes its new value on the clock edge that samples `start`=1. It keeps that value, whatever the other inputs do, until the next such edge. Reset sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_wide_rst_n | input | 1 | Upstream-side wide-request line, sampled during reset |
| start | input | 1 | One-cycle pulse that latches the transaction description |
| cmd | input | 3 | Command class code |
| start_dwa | input | DWA_W (30) | Start address in DWORDs (byte address bits 31:2) |
| dw_count | input | CNT_W (10) | Transfer length in DWORDs |
| line_dw | input | LINE_W (8) | Cache line size in DWORDs |
| upstream | input | 1 | 1 for an upstream transaction |
| resume | input | 1 | 1 when resuming a write after a target disconnect |
| prev_ack_wide | input | 1 | 1 if the previous target acknowledged a wide transfer |
| prev_retry | input | 1 | 1 if the previous target terminated with a retry |
| frame_n | input | 1 | Frame strobe driven by the master, active low |
| wide_req_n | output | 1 | Wide-request strobe, active low |
| wide_mode | output | 1 | 1 for a 64-bit transaction, 0 for 32-bit |

## Verification
The bench builds the block with its default widths: a 30-bit DWORD address, a 10-bit count and an 8-bit line size. These widths let it use cache lines of 8 and 16 DWORDs and place starts on both sides of the last-quadword boundary. It can also reach counts right at the one- and two-DWORD limits. Three resets with different levels on the upstream wide line bring both captured states within reach, and show that the line is ignored once reset has ended.

// File: rtl/wreq_pkg.sv
// Shared types for the wide transfer request decider.
// Assumes the command code set is fixed at 3 bits; codes 6 and 7 are unused.
package wreq_pkg;

    typedef enum logic [2:0] {
        CMD_MRD    = 3'd0,
        CMD_MRD_NP = 3'd1,
        CMD_MWR    = 3'd2,
        CMD_IO     = 3'd3,
        CMD_CFG    = 3'd4,
        CMD_SPC    = 3'd5
    } xfer_cmd_e;

    // Bit positions of the individual narrowing reasons.
    localparam int V_CMD      = 0;
    localparam int V_ALIGN    = 1;
    localparam int V_LINE_TOP = 2;
    localparam int V_SHORT_RD = 3;
    localparam int V_SHORT_WR = 4;
    localparam int V_UP_CAP   = 5;
    localparam int V_RESUME   = 6;
    localparam int NUM_VETO   = 7;

endpackage

// File: rtl/wreq_cap.sv
// Captures the upstream wide-request line level while reset is held and
// keeps the last sample afterwards. The line is active low, so a captured 1
// on up_wide_ok means the upstream side can take wide transfers.
// Assumes reset is held for at least one clock edge.
module wreq_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic up_wide_rst_n,
    output logic up_wide_ok
);

    // Sample on every reset edge; hold once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) up_wide_ok <= ~up_wide_rst_n;
    end

    // R7: the captured level never moves outside reset.
    p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(up_wide_ok));

endmodule

// File: rtl/wreq_rules.sv
// Evaluates every condition that forces a 32-bit transfer and returns one
// veto bit per condition. This block is purely combinational.
// Assumes line_dw is a power of two and at least 8.
module wreq_rules
    import wreq_pkg::*;
#(
    parameter int DWA_W  = 30,
    parameter int CNT_W  = 10,
    parameter int LINE_W = 8
) (
    input  logic [2:0]          cmd,
    input  logic [DWA_W-1:0]    start_dwa,
    input  logic [CNT_W-1:0]    dw_count,
    input  logic [LINE_W-1:0]   line_dw,
    input  logic                upstream,
    input  logic                up_wide_ok,
    input  logic                resume,
    input  logic                prev_ack_wide,
    input  logic                prev_retry,
    output logic [NUM_VETO-1:0] veto
);

    localparam logic [CNT_W-1:0] ONE_DW = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO_DW = CNT_W'(2);

    logic [DWA_W-1:0] line_mask;
    logic [DWA_W-1:0] line_off;
    logic             is_rd;
    logic             is_wr;

    // Offset of the start DWORD inside its cache line.
    always_comb begin
        line_mask = DWA_W'(line_dw) - DWA_W'(1);
        line_off  = start_dwa & line_mask;
    end

    // Classify the command and raise one veto per narrowing condition.
    always_comb begin
        is_rd = (cmd == CMD_MRD);
        is_wr = (cmd == CMD_MWR);
        veto             = '0;
        veto[V_CMD]      = !(is_rd || is_wr);
        veto[V_ALIGN]    = start_dwa[0];
        veto[V_LINE_TOP] = (line_off >= line_mask - DWA_W'(1));
        veto[V_SHORT_RD] = is_rd && (dw_count <= ONE_DW);
        veto[V_SHORT_WR] = is_wr && (dw_count <= TWO_DW);
        veto[V_UP_CAP]   = upstream && !up_wide_ok;
        veto[V_RESUME]   = is_wr && resume && !prev_ack_wide && !prev_retry;
    end

endmodule

// File: rtl/wreq_strobe.sv
// Holds the per-transaction mode decision and gates the frame strobe onto
// the wide-request strobe, so both change on the same edges.
// Assumes start is not pulsed while the frame strobe is active.
module wreq_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic go_wide,
    input  logic frame_n,
    output logic wide_mode,
    output logic wide_req_n
);

    // Latch the decision at the start pulse; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     wide_mode <= 1'b0;
        else if (start) wide_mode <= go_wide;
    end

    // Follow the frame strobe only while in wide mode.
    always_comb wide_req_n = frame_n | ~wide_mode;

    // R10: without a start pulse the mode does not change.
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(wide_mode));

    // R1: the request strobe is never active outside a frame.
    p_req_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_req_n |-> !frame_n);

    // R1: the request releases on the same edge as the frame.
    p_req_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> wide_req_n);

endmodule

// File: rtl/wide_req_decider.sv
// Top of the wide transfer request decider. It combines the reset-time
// capture, the rule evaluator and the strobe stage.
// Assumes the master gives start one cycle before asserting frame.
module wide_req_decider
    import wreq_pkg::*;
#(
    parameter int DWA_W  = 30,
    parameter int CNT_W  = 10,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_wide_rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [DWA_W-1:0]  start_dwa,
    input  logic [CNT_W-1:0]  dw_count,
    input  logic [LINE_W-1:0] line_dw,
    input  logic              upstream,
    input  logic              resume,
    input  logic              prev_ack_wide,
    input  logic              prev_retry,
    input  logic              frame_n,
    output logic              wide_req_n,
    output logic              wide_mode
);

    logic                up_wide_ok;
    logic [NUM_VETO-1:0] veto;
    logic                go_wide;

    wreq_cap u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_wide_rst_n (up_wide_rst_n),
        .up_wide_ok    (up_wide_ok)
    );

    wreq_rules #(
        .DWA_W  (DWA_W),
        .CNT_W  (CNT_W),
        .LINE_W (LINE_W)
    ) u_rules (
        .cmd           (cmd),
        .start_dwa     (start_dwa),
        .dw_count      (dw_count),
        .line_dw       (line_dw),
        .upstream      (upstream),
        .up_wide_ok    (up_wide_ok),
        .resume        (resume),
        .prev_ack_wide (prev_ack_wide),
        .prev_retry    (prev_retry),
        .veto          (veto)
    );

    // Wide only when no condition objects.
    always_comb go_wide = ~|veto;

    wreq_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .go_wide    (go_wide),
        .frame_n    (frame_n),
        .wide_mode  (wide_mode),
        .wide_req_n (wide_req_n)
    );

    // R2: command classes other than prefetchable read and write stay narrow.
    p_cmd_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && (cmd != CMD_MRD) && (cmd != CMD_MWR) |=> !wide_mode);

    // R3: a misaligned start stays narrow.
    p_align_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start && start_dwa[0] |=> !wide_mode);

    // R7: upstream work is narrow when the upstream side lacked the capability.
    p_up_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start && upstream && !up_wide_ok |=> !wide_mode);

    // R8: a resumed write without a prior acknowledge stays narrow unless retried.
    p_resume_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && (cmd == CMD_MWR) && resume && !prev_ack_wide && !prev_retry
        |=> !wide_mode);

endmodule

// File: tb/wide_req_decider_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset state and the reset-time capture.
module wide_req_decider_bench;

    localparam int AW = 30;
    localparam int CW = 10;
    localparam int LW = 8;

    typedef struct packed {
        logic [2:0]    cmd;
        logic [AW-1:0] dwa;
        logic [CW-1:0] cnt;
        logic [LW-1:0] cls;
        logic          up;
        logic          res;
        logic          ack;
        logic          rty;
        logic          exp;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 30'h40, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9}, // R9 plain read
        '{3'd2, 30'h40, 10'd8,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9}, // R9 plain write
        '{3'd1, 30'h40, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 np read
        '{3'd3, 30'h40, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 io
        '{3'd4, 30'h40, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 cfg
        '{3'd5, 30'h40, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 special
        '{3'd7, 30'h40, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 unused code
        '{3'd0, 30'h41, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 misaligned
        '{3'd2, 30'h43, 10'd8,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 write
        '{3'd0, 30'h46, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 last qw, line 8
        '{3'd0, 30'h44, 10'd4,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4}, // R4 one below
        '{3'd0, 30'h4E, 10'd4,  8'd16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 last qw, line 16
        '{3'd0, 30'h46, 10'd4,  8'd16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4}, // R4 mid line 16
        '{3'd0, 30'h40, 10'd1,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 single read
        '{3'd0, 30'h40, 10'd2,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5}, // R5 two dw read
        '{3'd2, 30'h40, 10'd1,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 one dw write
        '{3'd2, 30'h40, 10'd2,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 two dw write
        '{3'd2, 30'h40, 10'd3,  8'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6}, // R6 three dw write
        '{3'd0, 30'h40, 10'd4,  8'd8,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7}, // R7 up, capable
        '{3'd2, 30'h40, 10'd8,  8'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 no ack
        '{3'd2, 30'h40, 10'd8,  8'd8,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 retry ignores
        '{3'd2, 30'h40, 10'd8,  8'd8,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8}, // R8 acked
        '{3'd2, 30'h40, 10'd8,  8'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 not resumed
        '{3'd0, 30'h40, 10'd8,  8'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 read ignores
        '{3'd3, 30'h41, 10'd1,  8'd8,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 combined
        '{3'd2, 30'h46, 10'd2,  8'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}  // R6 combined
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_wide_rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    cmd = '0;
    logic [AW-1:0] start_dwa = '0;
    logic [CW-1:0] dw_count = '0;
    logic [LW-1:0] line_dw = 8'd8;
    logic          upstream = 1'b0;
    logic          resume = 1'b0;
    logic          prev_ack_wide = 1'b1;
    logic          prev_retry = 1'b0;
    logic          frame_n = 1'b1;
    logic          wide_req_n;
    logic          wide_mode;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wide_req_decider u_wide_req_decider (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_wide_rst_n (up_wide_rst_n),
        .start         (start),
        .cmd           (cmd),
        .start_dwa     (start_dwa),
        .dw_count      (dw_count),
        .line_dw       (line_dw),
        .upstream      (upstream),
        .resume        (resume),
        .prev_ack_wide (prev_ack_wide),
        .prev_retry    (prev_retry),
        .frame_n       (frame_n),
        .wide_req_n    (wide_req_n),
        .wide_mode     (wide_mode)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic line_lvl);
        @(negedge clk);
        rst_n = 1'b0;
        frame_n = 1'b0;
        up_wide_rst_n = line_lvl;
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset mode", wide_mode, 1'b0);
        check("R1 reset strobe", wide_req_n, 1'b1);
        frame_n = 1'b1;
        rst_n = 1'b1;
        up_wide_rst_n = ~line_lvl; // level after reset must be ignored (R7)
    endtask

    // Start a transaction, run a three-beat frame, and check mode and strobe.
    task automatic run_txn(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.rq);
        @(negedge clk);
        cmd = v.cmd; start_dwa = v.dwa; dw_count = v.cnt; line_dw = v.cls;
        upstream = v.up; resume = v.res; prev_ack_wide = v.ack; prev_retry = v.rty;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(tag, wide_mode, v.exp);
        check({tag, " idle strobe"}, wide_req_n, 1'b1);
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            frame_n = 1'b0;
            // disturb the description without start: no effect expected (R10)
            cmd = 3'd3; start_dwa = ~v.dwa; dw_count = '0; upstream = ~v.up;
            #1;
            check({tag, " R1 strobe in frame"}, wide_req_n, ~v.exp);
        end
        @(negedge clk);
        frame_n = 1'b1;
        #1;
        check("R1 strobe after frame", wide_req_n, 1'b1);
        check("R10 mode held", wide_mode, v.exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        vec_t v;
        // capable upstream side: line asserted (low) in reset
        do_reset(1'b0);
        for (int i = 0; i < NV; i++) run_txn(VECS[i]);

        // R7: line not asserted in reset -> upstream narrow, downstream wide
        do_reset(1'b1);
        v = VECS[0];
        v.up = 1'b1; v.exp = 1'b0; v.rq = 4'd7;
        run_txn(v);
        v.up = 1'b0; v.exp = 1'b1;
        run_txn(v);

        // R7: capable again; the line going high after reset has no effect
        do_reset(1'b0);
        v.up = 1'b1; v.exp = 1'b1;
        run_txn(v);

        // R10: a new start replaces the held mode on its own edge
        v = VECS[13];
        run_txn(v);
        run_txn(VECS[0]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule